// File: doc/BRIEF.md
# DMA Destination Address and Acknowledge Sequencer

This block is the destination side of one DMA channel that moves data in dual-address form: every transfer is a read cycle followed by a write cycle, both run by an external bus stub. The stub tells the block which phase is in progress and marks the last clock of the write cycle. On that clock the block moves its destination address register by a step. The step follows the programmed address mode (fixed, increment or decrement) and the transfer unit size. The block also drives an acknowledge strobe during one chosen phase with a programmable polarity.

Software reaches two registers through a plain write/read port: a channel control register and the destination address register, which software can load directly. The channel number is a parameter. Only channels 0 and 1 carry the acknowledge phase and polarity bits. On higher channels those bits cannot be written and read back as zero. In that case the strobe stays active-low and appears in the read phase. Settings that may not be used raise an error flag, and while one is active the address is frozen.

Register select `reg_sel`: 0 = control register, 1 = destination address. Control register fields: bits [1:0] address mode, bits [3:2] unit size, bit 4 acknowledge phase, bit 5 acknowledge polarity. All other bits read as 0.

Top module: `dma_dst_seq`

## Requirements
- R1: After reset the control register reads 0, the destination address is 0, `cfg_err` is 0 and `dack` is 1 (inactive for an active-low strobe).
- R2: With mode 01 (increment), each completed transfer raises the address by 1, 2, 4 or 16 for unit size 00 (8-bit), 01 (16-bit), 10 (32-bit) or 11 (16-byte).
- R3: With mode 10 (decrement) and unit size 00, 01 or 10, each completed transfer lowers the address by 1, 2 or 4, wrapping modulo 2^32.
- R4: With mode 00 (fixed), the address does not change across transfers.
- R5: Mode 11 sets `cfg_err` to 1 and the address is held across transfers.
- R6: Mode 10 together with unit size 11 sets `cfg_err` to 1 and the address is held across transfers.
- R7: The address changes only on a clock where `phase_wr` and `wr_last` are both 1, or where software writes it. The new value is visible from the following cycle. `wr_last` without `phase_wr`, and the read phase, leave the address untouched.
- R8: Control bit 4 = 0 places the strobe in the read phase (`phase_rd`); bit 4 = 1 places it in the write phase (`phase_wr`). The strobe is asserted for exactly the cycles of that phase.
- R9: Control bit 5 = 0 gives an active-low strobe and 1 gives an active-high strobe. Outside the selected phase `dack` sits at the inactive level.
- R10: On channels 2 and 3, control bits 4 and 5 ignore writes and read back 0, so the strobe stays active-low in the read phase.
- R11: Software writes with `reg_sel`=1 load the address, and increment wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = destination address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| phase_rd | input | 1 | Bus stub is in the read cycle |
| phase_wr | input | 1 | Bus stub is in the write cycle |
| wr_last | input | 1 | Last clock of the write cycle |
| dst_addr | output | 32 | Current destination address |
| dack | output | 1 | Acknowledge strobe |
| cfg_err | output | 1 | Illegal address-mode setting |

## Verification
The assertions assume a well-behaved bus stub. `phase_rd` and `phase_wr` are never high together, `wr_last` comes during a write phase, and software does not write the address on the clock that ends a transfer. The bench drives each transfer as one read clock followed by one write clock that carries `wr_last`, with all inputs changed on the falling edge. Register writes happen only between transfers. One deliberate `wr_last` outside a write phase exercises R7; it never coincides with an address write.

// File: rtl/dma_dst_pkg.sv
package dma_dst_pkg;
  parameter int unsigned AW = 32;
  parameter int unsigned CW = 6;

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_DEC   = 2'b10,
    AM_RSVD  = 2'b11
  } addr_mode_e;

  typedef struct packed {
    logic       ack_hi;
    logic       ack_wr;
    logic [1:0] unit;
    addr_mode_e mode;
  } ctrl_t;

  function automatic logic [AW-1:0] unit_step(input logic [1:0] unit);
    logic [AW-1:0] s;
    s = '0;
    case (unit)
      2'b00:   s[0] = 1'b1;
      2'b01:   s[1] = 1'b1;
      2'b10:   s[2] = 1'b1;
      default: s[4] = 1'b1;
    endcase
    return s;
  endfunction

  function automatic logic mode_illegal(input addr_mode_e m, input logic [1:0] unit);
    return (m == AM_RSVD) || (m == AM_DEC && unit == 2'b11);
  endfunction

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a,
                                            input addr_mode_e m,
                                            input logic [1:0] unit);
    case (m)
      AM_INC:  return a + unit_step(unit);
      AM_DEC:  return a - unit_step(unit);
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_dst_pkg::*;
#(
  parameter int unsigned CHANNEL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output ctrl_t         ctrl
);
  logic [1:0] mode_q;
  logic [1:0] unit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      unit_q <= 2'b00;
    end else if (we) begin
      mode_q <= wdata[1:0];
      unit_q <= wdata[3:2];
    end
  end

  assign ctrl.mode = addr_mode_e'(mode_q);
  assign ctrl.unit = unit_q;

  generate
    if (CHANNEL < 2) begin : g_ack_bits
      logic wr_q, hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wr_q <= 1'b0;
          hi_q <= 1'b0;
        end else if (we) begin
          wr_q <= wdata[4];
          hi_q <= wdata[5];
        end
      end
      assign ctrl.ack_wr = wr_q;
      assign ctrl.ack_hi = hi_q;
    end else begin : g_no_ack_bits
      logic unused_ack_wdata;
      assign unused_ack_wdata = &{1'b0, wdata[5:4]};
      assign ctrl.ack_wr = 1'b0;
      assign ctrl.ack_hi = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_dst_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  ctrl_t         ctrl,
  output logic          illegal,
  output logic [AW-1:0] addr
);
  assign illegal = mode_illegal(ctrl.mode, ctrl.unit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr <= '0;
    else if (load)
      addr <= load_val;
    else if (step_en && !illegal)
      addr <= advance(addr, ctrl.mode, ctrl.unit);
  end
endmodule

// File: rtl/dma_ack_gen.sv
module dma_ack_gen (
  input  logic phase_rd,
  input  logic phase_wr,
  input  logic ack_wr,
  input  logic ack_hi,
  output logic ack_active,
  output logic dack
);
  assign ack_active = ack_wr ? phase_wr : phase_rd;
  assign dack       = ack_hi ? ack_active : ~ack_active;
endmodule

// File: rtl/dma_dst_seq.sv
module dma_dst_seq
  import dma_dst_pkg::*;
#(
  parameter int unsigned CHANNEL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          phase_rd,
  input  logic          phase_wr,
  input  logic          wr_last,
  output logic [AW-1:0] dst_addr,
  output logic          dack,
  output logic          cfg_err
);
  ctrl_t ctrl;
  logic  ctrl_we;
  logic  addr_we;
  logic  upd_evt;
  logic  ack_active;

  assign ctrl_we = reg_we && !reg_sel;
  assign addr_we = reg_we && reg_sel;
  assign upd_evt = phase_wr && wr_last;

  dma_ctrl_reg #(.CHANNEL(CHANNEL)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_we),
    .wdata (reg_wdata[CW-1:0]),
    .ctrl  (ctrl)
  );

  dma_addr_unit u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (addr_we),
    .load_val (reg_wdata),
    .step_en  (upd_evt),
    .ctrl     (ctrl),
    .illegal  (cfg_err),
    .addr     (dst_addr)
  );

  dma_ack_gen u_ack (
    .phase_rd   (phase_rd),
    .phase_wr   (phase_wr),
    .ack_wr     (ctrl.ack_wr),
    .ack_hi     (ctrl.ack_hi),
    .ack_active (ack_active),
    .dack       (dack)
  );

  assign reg_rdata = reg_sel ? dst_addr : {{(AW-CW){1'b0}}, ctrl};
endmodule

// File: rtl/dma_dst_seq_chk.sv
module dma_dst_seq_chk
  import dma_dst_pkg::*;
#(
  parameter int unsigned CHANNEL = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic [AW-1:0] reg_rdata,
  input logic          addr_we,
  input logic          upd_evt,
  input logic          phase_rd,
  input logic          phase_wr,
  input logic [1:0]    mode,
  input logic [1:0]    unit,
  input logic          ack_hi,
  input logic [AW-1:0] dst_addr,
  input logic          dack,
  input logic          cfg_err
);
  logic [AW-1:0] exp_step;
  always_comb begin
    case (unit)
      2'b00:   exp_step = 32'd1;
      2'b01:   exp_step = 32'd2;
      2'b10:   exp_step = 32'd4;
      default: exp_step = 32'd16;
    endcase
  end

  // R7
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !addr_we) |=> $stable(dst_addr));

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !addr_we && cfg_err) |=> $stable(dst_addr));

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !addr_we && mode == 2'b01) |=> ((dst_addr - $past(dst_addr)) == $past(exp_step)));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !addr_we && mode == 2'b10 && unit != 2'b11) |=> (($past(dst_addr) - dst_addr) == $past(exp_step)));

  // R6
  dec_burst_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && unit == 2'b11) |-> cfg_err);

  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_rd && !phase_wr) |-> (dack == !ack_hi));

  // R10
  no_ack_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CHANNEL >= 2 && !reg_sel) |-> (reg_rdata[5:4] == 2'b00));
endmodule

bind dma_dst_seq dma_dst_seq_chk #(.CHANNEL(CHANNEL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .addr_we   (addr_we),
  .upd_evt   (upd_evt),
  .phase_rd  (phase_rd),
  .phase_wr  (phase_wr),
  .mode      (ctrl.mode),
  .unit      (ctrl.unit),
  .ack_hi    (ctrl.ack_hi),
  .dst_addr  (dst_addr),
  .dack      (dack),
  .cfg_err   (cfg_err)
);

// File: tb/dma_dst_seq_tb.sv
`timescale 1ns/1ps
module dma_dst_seq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic        phase_rd = 0, phase_wr = 0, wr_last = 0;
  logic [31:0] rdata0, rdata2, addr0, addr2;
  logic        dack0, dack2, err0, err2;
  int checks = 0, errors = 0;
  logic ack_rd_s, ack_wr_s, ack_idle_s, ack2_rd_s, ack2_wr_s;

  always #2.5 clk = ~clk;

  dma_dst_seq #(.CHANNEL(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .phase_rd(phase_rd),
    .phase_wr(phase_wr), .wr_last(wr_last), .dst_addr(addr0),
    .dack(dack0), .cfg_err(err0));

  dma_dst_seq #(.CHANNEL(2)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata2), .phase_rd(phase_rd),
    .phase_wr(phase_wr), .wr_last(wr_last), .dst_addr(addr2),
    .dack(dack2), .cfg_err(err2));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] a, input logic [1:0] m,
                                             input logic [1:0] u);
    int unsigned st;
    st = (u == 2'd3) ? 16 : (1 << u);
    if (m == 2'd1) return a + st;
    if (m == 2'd2 && u != 2'd3) return a - st;
    return a;
  endfunction

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic xfer();
    @(negedge clk);
    phase_rd = 1;
    #1 ack_rd_s = dack0; ack2_rd_s = dack2;
    @(negedge clk);
    phase_rd = 0; phase_wr = 1; wr_last = 1;
    #1 ack_wr_s = dack0; ack2_wr_s = dack2;
    @(negedge clk);
    phase_wr = 0; wr_last = 0;
    #1 ack_idle_s = dack0;
  endtask

  task automatic t_reset();
    reg_sel = 0; #1;
    check("R1 ctrl", rdata0, 0);
    check("R1 addr", addr0, 0);
    check("R1 err", {31'b0, err0}, 0);
    check("R1 dack", {31'b0, dack0}, 1);
  endtask

  task automatic t_inc();
    for (int u = 0; u < 4; u++) begin
      wr_reg(1, 32'h1000);
      wr_reg(0, {28'b0, u[1:0], 2'b01});
      xfer();
      check("R2 inc", addr0, model_next(32'h1000, 2'd1, u[1:0]));
      xfer();
      check("R2 inc twice", addr0, model_next(model_next(32'h1000, 2'd1, u[1:0]), 2'd1, u[1:0]));
    end
  endtask

  task automatic t_dec();
    for (int u = 0; u < 3; u++) begin
      wr_reg(1, 32'h2);
      wr_reg(0, {28'b0, u[1:0], 2'b10});
      check("R3 no err", {31'b0, err0}, 0);
      xfer();
      check("R3 dec", addr0, model_next(32'h2, 2'd2, u[1:0]));
    end
    check("R3 wrap", addr0, 32'hFFFF_FFFE);
  endtask

  task automatic t_fixed();
    wr_reg(1, 32'hABCD_0000);
    wr_reg(0, 32'h0000_000C);
    xfer(); xfer();
    check("R4 fixed", addr0, 32'hABCD_0000);
  endtask

  task automatic t_err();
    wr_reg(1, 32'h500);
    wr_reg(0, 32'h0000_0003);
    check("R5 err", {31'b0, err0}, 1);
    xfer();
    check("R5 hold", addr0, 32'h500);
    wr_reg(0, 32'h0000_000E);
    check("R6 err", {31'b0, err0}, 1);
    xfer();
    check("R6 hold", addr0, 32'h500);
    wr_reg(0, 32'h0000_000D);
    check("R6 inc burst legal", {31'b0, err0}, 0);
  endtask

  task automatic t_timing();
    wr_reg(1, 32'h40);
    wr_reg(0, 32'h0000_0009);
    @(negedge clk);
    wr_last = 1;
    @(negedge clk);
    wr_last = 0;
    check("R7 wr_last alone", addr0, 32'h40);
    @(negedge clk);
    phase_rd = 1;
    @(negedge clk);
    phase_rd = 0; phase_wr = 1; wr_last = 1;
    #1 check("R7 not yet", addr0, 32'h40);
    @(negedge clk);
    phase_wr = 0; wr_last = 0;
    check("R7 after write", addr0, 32'h44);
  endtask

  task automatic t_ack();
    for (int k = 0; k < 4; k++) begin
      logic wrsel, hi;
      wrsel = k[0]; hi = k[1];
      wr_reg(0, {26'b0, hi, wrsel, 4'b0000});
      xfer();
      check("R8 rd phase", {31'b0, ack_rd_s}, {31'b0, hi ~^ !wrsel});
      check("R8 wr phase", {31'b0, ack_wr_s}, {31'b0, hi ~^ wrsel});
      check("R9 idle", {31'b0, ack_idle_s}, {31'b0, !hi});
    end
  endtask

  task automatic t_ch2();
    wr_reg(0, 32'h0000_0031);
    reg_sel = 0; #1;
    check("R10 ch2 readback", rdata2, 32'h1);
    check("R10 ch0 readback", rdata0, 32'h31);
    xfer();
    check("R10 ch2 rd ack", {31'b0, ack2_rd_s}, 0);
    check("R10 ch2 wr ack", {31'b0, ack2_wr_s}, 1);
  endtask

  task automatic t_wrap();
    wr_reg(1, 32'hFFFF_FFF8);
    reg_sel = 1; #1;
    check("R11 load readback", rdata0, 32'hFFFF_FFF8);
    wr_reg(0, 32'h0000_000D);
    xfer();
    check("R11 wrap", addr0, 32'h0000_0008);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_inc();
    t_dec();
    t_fixed();
    t_err();
    t_timing();
    t_ack();
    t_ch2();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule